// File: doc/BRIEF.md
# I2C Target Receiver/Transmitter with Clock Hold

This block is the target (responding) side of a two-wire serial bus. It watches the clock and data lines through synchronizers and a short glitch filter. It finds start, repeated start and stop conditions and collects a 7-bit address and a direction bit. If the address is its own, it acknowledges and then moves bytes between the bus and a byte-wide local interface. It never drives either line high. For each line it has a pull-low enable (`scl_oe`, `sda_oe`), and the pad logic turns an enable of 1 into a driven low.

On a write, received bytes are handed to local logic one at a time. A byte that arrives while local logic reports its buffer full is refused with a NACK. The all-zero address with the write direction is treated as a general call. After it, the command byte 0x06 produces a one-cycle reset pulse toward local logic. On a read, the block loads a byte from local logic and shifts it out. It keeps loading new bytes for as long as the master acknowledges. After every acknowledged byte, the block can hold the clock line low until local logic says it is ready.

Top module: `i2c_target_stretch`

## Requirements
- R1: A falling edge of SDA while SCL is high (start) puts the block into address collection from any state.
- R2: When the 7 address bits (MSB first) equal `own_addr`, the block pulls SDA low during the ninth clock. Bit 0 of the first byte selects the direction (1 = read, 0 = write).
- R3: When the address matches neither `own_addr` nor the general call, SDA is never pulled low until the next start.
- R4: On a write, each byte received MSB first appears on `rx_data` with a single-cycle `rx_valid`, and it is acknowledged.
- R5: A write byte that completes while `rx_full` is 1 is not acknowledged and raises no `rx_valid`.
- R6: Address 0000000 with the write direction is acknowledged. A following byte 0x06 gives exactly one single-cycle `gc_reset` pulse; other general call bytes give none. General call bytes are acknowledged and never reach `rx_data`, even while `rx_full` is 1.
- R7: After an acknowledged ninth clock, if `loc_rdy` is 0, the block holds SCL low (`scl_oe` = 1) until `loc_rdy` is 1. It never holds SCL once `loc_rdy` has been 1 for a cycle.
- R8: On a read, `tx_data` is loaded with a single-cycle `tx_take` and sent MSB first. A further byte is loaded after each master ACK.
- R9: After a master NACK, SDA stays released and no further byte is loaded until a new start.
- R10: A stop (SDA rising while SCL is high) returns the block to idle and discards a partly received byte.
- R11: A repeated start in the middle of a byte restarts address collection. The partial byte is dropped.
- R12: After reset both enables are 0. `sda_oe` changes only while the filtered SCL is low.
- R13: A low pulse on SCL that lasts one clock cycle is filtered out and does not count as a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed serial clock line |
| sda_i | input | 1 | Sensed serial data line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | 7 | Own 7-bit target address |
| rx_data | output | 8 | Last received write byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_full | input | 1 | Local receive buffer cannot take a byte |
| tx_data | input | 8 | Byte to send on a read |
| tx_take | output | 1 | One-cycle strobe when `tx_data` is loaded |
| loc_rdy | input | 1 | Local logic ready; 0 requests a clock hold |
| gc_reset | output | 1 | One-cycle general call reset pulse |

## Verification
The general call decision and the full-buffer refusal are both taken on the same falling edge at the end of the eighth data bit. The bench provokes this by keeping `rx_full` high through a general call write of 0x06 followed by a second command byte. It passes the case only if both bytes are acknowledged, exactly one reset pulse appears, and `rx_valid` stays low. A bench model keeps a queue of expected write bytes and running counts of reset and load strobes. On every clock it compares the outputs against these and against the length of the ready run that allows a clock hold.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RX   = 3'd1,
    ST_ACK  = 3'd2,
    ST_HOLD = 3'd3,
    ST_TX   = 3'd4,
    ST_MACK = 3'd5
  } i2ct_state_e;

  localparam int GC_RESET_CODE = 6;

endpackage

// File: rtl/i2ct_line_filter.sv
module i2ct_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [FILT_LEN-1:0]    hist_q, hist_d;
  logic                   out_q, out_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
    hist_d = {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
    out_d  = out_q;
    if (&hist_q)
      out_d = 1'b1;
    else if (~|hist_q)
      out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
      out_q  <= out_d;
    end
  end

  assign line_o = out_q;

endmodule

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_det = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;

endmodule

// File: rtl/i2ct_core.sv
module i2ct_core
  import i2ct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_f,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              rx_full,
  input  logic              loc_rdy,
  input  logic [DATA_W-1:0] tx_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              tx_take,
  output logic              gc_reset,
  output logic              sda_oe,
  output logic              scl_oe
);

  localparam int ADDR_W = DATA_W - 1;
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(DATA_W - 1);
  localparam logic [DATA_W-1:0] GC_CMD   = DATA_W'(GC_RESET_CODE);

  i2ct_state_e       state_q, state_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              is_addr_q, is_addr_d;
  logic              go_tx_q, go_tx_d;
  logic              gc_mode_q, gc_mode_d;
  logic              mack_q, mack_d;
  logic              sda_oe_q, sda_oe_d;
  logic              scl_oe_q, scl_oe_d;
  logic [DATA_W-1:0] rx_data_q, rx_data_d;
  logic              rx_valid_d, tx_take_d, gc_rst_d;
  logic              rx_valid_q, tx_take_q, gc_rst_q;

  logic [ADDR_W-1:0] addr_field;
  logic              rw_bit, gc_hit, own_hit, advance;

  assign addr_field = sh_q[DATA_W-1:1];
  assign rw_bit     = sh_q[0];
  assign gc_hit     = (addr_field == '0) && !rw_bit;
  assign own_hit    = (addr_field == own_addr);

  always_comb begin
    state_d    = state_q;
    sh_d       = sh_q;
    cnt_d      = cnt_q;
    is_addr_d  = is_addr_q;
    go_tx_d    = go_tx_q;
    gc_mode_d  = gc_mode_q;
    mack_d     = mack_q;
    sda_oe_d   = sda_oe_q;
    rx_data_d  = rx_data_q;
    rx_valid_d = 1'b0;
    tx_take_d  = 1'b0;
    gc_rst_d   = 1'b0;
    advance    = 1'b0;

    case (state_q)
      ST_RX: begin
        if (scl_rise && cnt_q != CNT_FULL) begin
          sh_d  = {sh_q[DATA_W-2:0], sda_f};
          cnt_d = cnt_q + 1'b1;
        end else if (scl_fall && cnt_q == CNT_FULL) begin
          if (is_addr_q) begin
            if (own_hit || gc_hit) begin
              sda_oe_d  = 1'b1;
              go_tx_d   = rw_bit && !gc_hit;
              gc_mode_d = gc_hit;
              state_d   = ST_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end else if (gc_mode_q) begin
            sda_oe_d = 1'b1;
            gc_rst_d = (sh_q == GC_CMD);
            state_d  = ST_ACK;
          end else if (!rx_full) begin
            sda_oe_d   = 1'b1;
            rx_data_d  = sh_q;
            rx_valid_d = 1'b1;
            state_d    = ST_ACK;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_ACK: begin
        if (scl_fall) begin
          sda_oe_d = 1'b0;
          if (loc_rdy) advance = 1'b1;
          else         state_d = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (loc_rdy) advance = 1'b1;
      end
      ST_TX: begin
        if (scl_fall) begin
          if (cnt_q == CNT_LAST) begin
            sda_oe_d = 1'b0;
            state_d  = ST_MACK;
          end else begin
            sh_d     = {sh_q[DATA_W-2:0], 1'b0};
            sda_oe_d = !sh_q[DATA_W-2];
            cnt_d    = cnt_q + 1'b1;
          end
        end
      end
      ST_MACK: begin
        if (scl_rise) begin
          mack_d = !sda_f;
        end else if (scl_fall) begin
          if (!mack_q)      state_d = ST_IDLE;
          else if (loc_rdy) advance = 1'b1;
          else              state_d = ST_HOLD;
        end
      end
      default: ;
    endcase

    if (advance) begin
      cnt_d = '0;
      if (go_tx_q) begin
        sh_d      = tx_data;
        tx_take_d = 1'b1;
        sda_oe_d  = !tx_data[DATA_W-1];
        state_d   = ST_TX;
      end else begin
        is_addr_d = 1'b0;
        state_d   = ST_RX;
      end
    end

    if (stop_det) begin
      state_d    = ST_IDLE;
      sda_oe_d   = 1'b0;
      rx_valid_d = 1'b0;
      tx_take_d  = 1'b0;
      gc_rst_d   = 1'b0;
    end else if (start_det) begin
      state_d    = ST_RX;
      is_addr_d  = 1'b1;
      gc_mode_d  = 1'b0;
      go_tx_d    = 1'b0;
      cnt_d      = '0;
      sda_oe_d   = 1'b0;
      rx_valid_d = 1'b0;
      tx_take_d  = 1'b0;
      gc_rst_d   = 1'b0;
    end

    scl_oe_d = (state_d == ST_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sh_q       <= '0;
      cnt_q      <= '0;
      is_addr_q  <= 1'b0;
      go_tx_q    <= 1'b0;
      gc_mode_q  <= 1'b0;
      mack_q     <= 1'b0;
      sda_oe_q   <= 1'b0;
      scl_oe_q   <= 1'b0;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
      tx_take_q  <= 1'b0;
      gc_rst_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      sh_q       <= sh_d;
      cnt_q      <= cnt_d;
      is_addr_q  <= is_addr_d;
      go_tx_q    <= go_tx_d;
      gc_mode_q  <= gc_mode_d;
      mack_q     <= mack_d;
      sda_oe_q   <= sda_oe_d;
      scl_oe_q   <= scl_oe_d;
      rx_data_q  <= rx_data_d;
      rx_valid_q <= rx_valid_d;
      tx_take_q  <= tx_take_d;
      gc_rst_q   <= gc_rst_d;
    end
  end

  assign rx_data  = rx_data_q;
  assign rx_valid = rx_valid_q;
  assign tx_take  = tx_take_q;
  assign gc_reset = gc_rst_q;
  assign sda_oe   = sda_oe_q;
  assign scl_oe   = scl_oe_q;

endmodule

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [DATA_W-2:0] own_addr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_full,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_take,
  input  logic              loc_rdy,
  output logic              gc_reset
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    i2ct_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  i2ct_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2ct_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_f    (sda_f),
    .own_addr (own_addr),
    .rx_full  (rx_full),
    .loc_rdy  (loc_rdy),
    .tx_data  (tx_data),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .tx_take  (tx_take),
    .gc_reset (gc_reset),
    .sda_oe   (sda_oe),
    .scl_oe   (scl_oe)
  );

endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic sda_oe,
  input logic scl_oe,
  input logic loc_rdy,
  input logic rx_valid,
  input logic rx_full,
  input logic gc_reset,
  input logic tx_take
);

  // R12: the data enable moves only while the filtered clock is low
  p_sda_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_f));

  // R7: a clock hold exists only when ready was low the cycle before
  p_hold_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> !$past(loc_rdy));

  // R4: receive strobe lasts one cycle
  p_rx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5: no strobe from a decision taken while the buffer was full
  p_full_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !$past(rx_full));

  // R6: reset pulse lasts one cycle
  p_gc_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gc_reset |=> !gc_reset);

  // R8: load strobe lasts one cycle
  p_take_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> !tx_take);

endmodule

bind i2c_target_stretch i2ct_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_f   (scl_f),
  .sda_oe  (sda_oe),
  .scl_oe  (scl_oe),
  .loc_rdy (loc_rdy),
  .rx_valid(rx_valid),
  .rx_full (rx_full),
  .gc_reset(gc_reset),
  .tx_take (tx_take)
);

// File: tb/i2c_target_stretch_tb.sv
module i2c_target_stretch_tb;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl_lo, m_sda_lo;
  logic scl_bus, sda_bus;
  logic scl_oe, sda_oe;
  logic [7:0] rx_data, tx_data;
  logic rx_valid, rx_full, tx_take, loc_rdy, gc_reset;

  int checks = 0;
  int errors = 0;
  int gc_cnt = 0;
  int take_cnt = 0;
  int rx_cnt = 0;
  int rdy_run = 0;
  int stretch_cnt = 0;
  logic [7:0] exp_rx[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_bus = !(m_scl_lo || scl_oe);
  assign sda_bus = !(m_sda_lo || sda_oe);

  i2c_target_stretch u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_full(rx_full),
    .tx_data(tx_data), .tx_take(tx_take), .loc_rdy(loc_rdy),
    .gc_reset(gc_reset)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  // reference model, compared on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_cnt++;
        if (exp_rx.size() == 0) chk(1'b0, "R4 unexpected rx_valid", rx_data, 0);
        else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          chk(rx_data == e, "R4 rx_data", rx_data, e);
        end
      end
      if (gc_reset) gc_cnt++;
      if (tx_take) take_cnt++;
      if (scl_oe && rdy_run >= 2) chk(1'b0, "R7 hold while ready", 1, 0);
      if (loc_rdy) rdy_run++; else rdy_run = 0;
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b, input bit glitch, output logic seen);
    m_sda_lo = !b;
    wq();
    m_scl_lo = 1'b0;
    while (!scl_bus) begin @(negedge clk); stretch_cnt++; end
    if (glitch) begin
      repeat (Q/2) @(negedge clk);
      m_scl_lo = 1'b1;
      @(negedge clk);
      m_scl_lo = 1'b0;
      repeat (Q/2) @(negedge clk);
    end else repeat (Q) @(negedge clk);
    seen = sda_bus;
    repeat (Q) @(negedge clk);
    m_scl_lo = 1'b1;
    wq();
  endtask

  task automatic write_byte(input logic [7:0] v, input bit gl, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], gl, s);
    clock_bit(1'b1, 1'b0, s);
    ack = !s;
  endtask

  task automatic read_byte(output logic [7:0] v, input bit give_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, 1'b0, s); v[i] = s; end
    clock_bit(!give_ack, 1'b0, s);
  endtask

  task automatic start_c();
    m_sda_lo = 1'b1; wq(); m_scl_lo = 1'b1; wq();
  endtask

  task automatic rstart_c();
    m_sda_lo = 1'b0; wq(); m_scl_lo = 1'b0;
    while (!scl_bus) @(negedge clk);
    wq(); m_sda_lo = 1'b1; wq(); m_scl_lo = 1'b1; wq();
  endtask

  task automatic stop_c();
    m_sda_lo = 1'b1; wq(); m_scl_lo = 1'b0;
    while (!scl_bus) @(negedge clk);
    wq(); m_sda_lo = 1'b0; wq(); wq();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired (R1) actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack, s;
    logic [7:0] v;
    int base, gbase;
    rst_n = 1'b0; m_scl_lo = 1'b0; m_sda_lo = 1'b0;
    rx_full = 1'b0; loc_rdy = 1'b1; tx_data = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sda_oe == 0 && scl_oe == 0, "R12 enables after reset", {scl_oe, sda_oe}, 0);
    chk(rx_valid == 0 && gc_reset == 0, "R12 strobes after reset", {rx_valid, gc_reset}, 0);
    wq();

    // R1 R2 R4: plain write
    start_c();
    write_byte({OWN, 1'b0}, 0, ack);
    chk(ack == 1, "R1 R2 address ack", ack, 1);
    exp_rx.push_back(8'hA5);
    write_byte(8'hA5, 0, ack);
    chk(ack == 1, "R4 byte ack", ack, 1);
    exp_rx.push_back(8'h3C);
    write_byte(8'h3C, 0, ack);
    chk(ack == 1, "R4 byte ack 2", ack, 1);
    stop_c();
    chk(exp_rx.size() == 0, "R4 bytes delivered", exp_rx.size(), 0);

    // R3: other address
    base = rx_cnt;
    start_c();
    write_byte({7'h2B, 1'b0}, 0, ack);
    chk(ack == 0, "R3 foreign address nack", ack, 0);
    write_byte(8'h00, 0, ack);
    chk(ack == 0, "R3 silent on data", ack, 0);
    stop_c();
    chk(rx_cnt == base, "R3 no delivery", rx_cnt - base, 0);

    // R5: buffer full
    rx_full = 1'b1;
    base = rx_cnt;
    start_c();
    write_byte({OWN, 1'b0}, 0, ack);
    chk(ack == 1, "R5 address ack", ack, 1);
    write_byte(8'h11, 0, ack);
    chk(ack == 0, "R5 full nack", ack, 0);
    chk(rx_cnt == base, "R5 no rx_valid", rx_cnt - base, 0);
    stop_c();

    // R6: general call, buffer still full (same decision edge)
    gbase = gc_cnt;
    start_c();
    write_byte(8'h00, 0, ack);
    chk(ack == 1, "R6 general call ack", ack, 1);
    write_byte(8'h06, 0, ack);
    chk(ack == 1, "R6 reset command ack", ack, 1);
    chk(gc_cnt - gbase == 1, "R6 one reset pulse", gc_cnt - gbase, 1);
    write_byte(8'h07, 0, ack);
    chk(ack == 1, "R6 other command ack", ack, 1);
    chk(gc_cnt - gbase == 1, "R6 no extra pulse", gc_cnt - gbase, 1);
    chk(rx_cnt == base, "R6 bypasses rx", rx_cnt - base, 0);
    stop_c();
    rx_full = 1'b0;

    // R7: clock hold until ready
    loc_rdy = 1'b0;
    start_c();
    write_byte({OWN, 1'b0}, 0, ack);
    chk(ack == 1, "R7 address ack", ack, 1);
    stretch_cnt = 0;
    exp_rx.push_back(8'h5E);
    fork
      write_byte(8'h5E, 0, ack);
      begin repeat (60) @(negedge clk); loc_rdy = 1'b1; end
    join
    chk(stretch_cnt >= 40 && stretch_cnt <= 70, "R7 hold length", stretch_cnt, 52);
    chk(ack == 1, "R7 byte after hold ack", ack, 1);
    stop_c();

    // R8 R9: read, then master NACK
    base = take_cnt;
    tx_data = 8'hC3;
    start_c();
    write_byte({OWN, 1'b1}, 0, ack);
    chk(ack == 1, "R8 read address ack", ack, 1);
    tx_data = 8'h5A;
    read_byte(v, 1);
    chk(v == 8'hC3, "R8 first read byte", v, 8'hC3);
    read_byte(v, 0);
    chk(v == 8'h5A, "R8 second read byte", v, 8'h5A);
    chk(take_cnt - base == 2, "R8 two loads", take_cnt - base, 2);
    chk(sda_oe == 0, "R9 released after nack", sda_oe, 0);
    read_byte(v, 0);
    chk(v == 8'hFF, "R9 silent after nack", v, 8'hFF);
    chk(take_cnt - base == 2, "R9 no further load", take_cnt - base, 2);
    stop_c();

    // R10: stop inside a byte
    base = rx_cnt;
    start_c();
    write_byte({OWN, 1'b0}, 0, ack);
    for (int i = 0; i < 4; i++) clock_bit(i[0], 0, s);
    stop_c();
    chk(rx_cnt == base, "R10 partial dropped", rx_cnt - base, 0);

    // R11: repeated start after a byte and inside a byte
    start_c();
    write_byte({OWN, 1'b0}, 0, ack);
    exp_rx.push_back(8'h12);
    write_byte(8'h12, 0, ack);
    for (int i = 0; i < 3; i++) clock_bit(1'b1, 0, s);
    rstart_c();
    write_byte({OWN, 1'b0}, 0, ack);
    chk(ack == 1, "R11 rearmed address ack", ack, 1);
    exp_rx.push_back(8'h77);
    write_byte(8'h77, 0, ack);
    chk(ack == 1, "R11 byte after restart", ack, 1);
    tx_data = 8'h81;
    rstart_c();
    write_byte({OWN, 1'b1}, 0, ack);
    chk(ack == 1, "R1 restart to read", ack, 1);
    read_byte(v, 0);
    chk(v == 8'h81, "R11 read after restart", v, 8'h81);
    stop_c();

    // R13: glitched clock
    start_c();
    write_byte({OWN, 1'b0}, 1, ack);
    chk(ack == 1, "R13 glitched address ack", ack, 1);
    exp_rx.push_back(8'h96);
    write_byte(8'h96, 1, ack);
    chk(ack == 1, "R13 glitched byte ack", ack, 1);
    stop_c();

    wq();
    chk(exp_rx.size() == 0, "R4 R11 R13 all delivered", exp_rx.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule